// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the sixteen-state sequencer of a boundary-scan test port. It advances on the rising edge of the test clock, and the level of the mode-select input chosen at each edge picks the next state. From the current state it decodes the strobes that a separate instruction register and a separate data register need: capture, shift and update for each. It also drives a path select, an enable for the serial test-data output and an indication that the test logic is held in reset.

Two active-low reset inputs each force the sequencer into Test-Logic-Reset at once, whatever the clock is doing. One is the power-up reset and the other is a reset for the scan logic only. The shift strobes and the output enable change on the falling edge of the test clock, so a register that shifts on the next rising edge sees them stable for half a period. The capture, update, select and reset outputs are decoded directly from the state.

Top module: `tap_controller`

## Requirements
- R1: Driving either `pwrRstN` or `scanRstN` low moves the controller to Test-Logic-Reset at once, without a clock edge. While either is low, `testLogicRst` is 1 and all six capture, shift and update outputs and `tdoEnable` are 0.
- R2: On each rising `tck` edge the state follows the standard graph, with `tms` 1 taking the first branch listed:
  - Test-Logic-Reset goes to itself or to Run-Test/Idle.
  - Run-Test/Idle goes to Select-DR or stays in Run-Test/Idle.
  - Select-DR goes to Select-IR or Capture.
  - Select-IR goes to Test-Logic-Reset or Capture.
  - Capture goes to Exit1 or Shift.
  - Shift goes to Exit1 or stays in Shift.
  - Exit1 goes to Update or Pause.
  - Pause goes to Exit2 or stays in Pause.
  - Exit2 goes to Update or Shift.
  - Update goes to Select-DR or Run-Test/Idle.
- R3: Five rising edges with `tms` 1 reach Test-Logic-Reset from any state.
- R4: `testLogicRst` is 1 exactly while the state is Test-Logic-Reset.
- R5: `irSelect` is 1 exactly while the state is one of the seven instruction-column states (Select-IR through Update-IR). It is 0 in all other states, including Test-Logic-Reset and Run-Test/Idle.
- R6: `captureDr` is 1 exactly in Capture-DR and `captureIr` is 1 exactly in Capture-IR.
- R7: `shiftDr` and `shiftIr` are loaded on each falling `tck` edge. Each is 1 when the state at that edge is Shift-DR or Shift-IR respectively.
- R8: `updateDr` is 1 exactly in Update-DR and `updateIr` is 1 exactly in Update-IR.
- R9: `tdoEnable` is loaded on each falling `tck` edge. It is 1 when the state at that edge is either shift state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tms | input | 1 | Mode select, sampled on the rising edge |
| pwrRstN | input | 1 | Power-up reset, active low, asynchronous |
| scanRstN | input | 1 | Scan-logic reset, active low, asynchronous |
| testLogicRst | output | 1 | High in Test-Logic-Reset |
| irSelect | output | 1 | 1 = instruction path, 0 = data path |
| tdoEnable | output | 1 | Serial output enable, falling-edge register |
| captureDr | output | 1 | Parallel load of the data register |
| shiftDr | output | 1 | Data register shift, falling-edge register |
| updateDr | output | 1 | Data register update |
| captureIr | output | 1 | Parallel load of the instruction register |
| shiftIr | output | 1 | Instruction register shift, falling-edge register |
| updateIr | output | 1 | Instruction register update |

## Verification
An asynchronous reset and a mode-select transition can land in the same clock period. The bench provokes this by pulsing one of the resets between a rising edge that has just moved the state (often into a shift state) and the falling edge that follows. A correct result shows Test-Logic-Reset immediately after the pulse, and shift strobes and the output enable that stay low at that falling edge instead of following the state the rising edge had chosen. The combined strobes and select are compared with a bench state model after every rising edge, and the falling-edge outputs after every falling edge.

// File: rtl/tapctl_pkg.sv
package tapctl_pkg;

  localparam int STATE_W = 4;

  typedef enum logic [STATE_W-1:0] {
    ST_RESET  = 4'h0,
    ST_IDLE   = 4'h1,
    ST_SEL_DR = 4'h2,
    ST_CAP_DR = 4'h3,
    ST_SH_DR  = 4'h4,
    ST_X1_DR  = 4'h5,
    ST_PA_DR  = 4'h6,
    ST_X2_DR  = 4'h7,
    ST_UP_DR  = 4'h8,
    ST_SEL_IR = 4'h9,
    ST_CAP_IR = 4'hA,
    ST_SH_IR  = 4'hB,
    ST_X1_IR  = 4'hC,
    ST_PA_IR  = 4'hD,
    ST_X2_IR  = 4'hE,
    ST_UP_IR  = 4'hF
  } tapState_t;

  typedef struct packed {
    logic inReset;
    logic irPath;
    logic capDr;
    logic shDr;
    logic upDr;
    logic capIr;
    logic shIr;
    logic upIr;
  } tapStrobes_t;

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tapctl_pkg::*;
(
  input  logic        tck,
  input  logic        tms,
  input  logic        rstAny,
  output tapStrobes_t strobes
);

  tapState_t curState;
  tapState_t nxtState;

  always_ff @(posedge tck or posedge rstAny) begin
    if (rstAny) curState <= ST_RESET;
    else        curState <= nxtState;
  end

  always_comb begin
    nxtState = curState;
    unique case (curState)
      ST_RESET:  nxtState = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   nxtState = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: nxtState = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxtState = tms ? ST_X1_DR  : ST_SH_DR;
      ST_SH_DR:  nxtState = tms ? ST_X1_DR  : ST_SH_DR;
      ST_X1_DR:  nxtState = tms ? ST_UP_DR  : ST_PA_DR;
      ST_PA_DR:  nxtState = tms ? ST_X2_DR  : ST_PA_DR;
      ST_X2_DR:  nxtState = tms ? ST_UP_DR  : ST_SH_DR;
      ST_UP_DR:  nxtState = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: nxtState = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: nxtState = tms ? ST_X1_IR  : ST_SH_IR;
      ST_SH_IR:  nxtState = tms ? ST_X1_IR  : ST_SH_IR;
      ST_X1_IR:  nxtState = tms ? ST_UP_IR  : ST_PA_IR;
      ST_PA_IR:  nxtState = tms ? ST_X2_IR  : ST_PA_IR;
      ST_X2_IR:  nxtState = tms ? ST_UP_IR  : ST_SH_IR;
      ST_UP_IR:  nxtState = tms ? ST_SEL_DR : ST_IDLE;
      default:   nxtState = ST_RESET;
    endcase
  end

  // Instruction column occupies encodings 9..15
  always_comb begin
    strobes         = '0;
    strobes.inReset = (curState == ST_RESET);
    strobes.irPath  = (curState >= ST_SEL_IR);
    strobes.capDr   = (curState == ST_CAP_DR);
    strobes.shDr    = (curState == ST_SH_DR);
    strobes.upDr    = (curState == ST_UP_DR);
    strobes.capIr   = (curState == ST_CAP_IR);
    strobes.shIr    = (curState == ST_SH_IR);
    strobes.upIr    = (curState == ST_UP_IR);
  end

endmodule

// File: rtl/tap_outputs.sv
module tap_outputs
  import tapctl_pkg::*;
(
  input  logic        tck,
  input  logic        rstAny,
  input  tapStrobes_t strobes,
  output logic        testLogicRst,
  output logic        irSelect,
  output logic        tdoEnable,
  output logic        captureDr,
  output logic        shiftDr,
  output logic        updateDr,
  output logic        captureIr,
  output logic        shiftIr,
  output logic        updateIr
);

  logic shDrQ, shIrQ, oeQ;

  always_ff @(negedge tck or posedge rstAny) begin
    if (rstAny) begin
      shDrQ <= 1'b0;
      shIrQ <= 1'b0;
      oeQ   <= 1'b0;
    end else begin
      shDrQ <= strobes.shDr;
      shIrQ <= strobes.shIr;
      oeQ   <= strobes.shDr | strobes.shIr;
    end
  end

  assign testLogicRst = strobes.inReset;
  assign irSelect     = strobes.irPath;
  assign captureDr    = strobes.capDr;
  assign updateDr     = strobes.upDr;
  assign captureIr    = strobes.capIr;
  assign updateIr     = strobes.upIr;
  assign shiftDr      = shDrQ;
  assign shiftIr      = shIrQ;
  assign tdoEnable    = oeQ;

endmodule

// File: rtl/tap_controller.sv
module tap_controller
  import tapctl_pkg::*;
(
  input  logic tck,
  input  logic tms,
  input  logic pwrRstN,
  input  logic scanRstN,
  output logic testLogicRst,
  output logic irSelect,
  output logic tdoEnable,
  output logic captureDr,
  output logic shiftDr,
  output logic updateDr,
  output logic captureIr,
  output logic shiftIr,
  output logic updateIr
);

  logic        rstAny;
  tapStrobes_t strobes;

  assign rstAny = ~pwrRstN | ~scanRstN;

  tap_fsm i_fsm (
    .tck     (tck),
    .tms     (tms),
    .rstAny  (rstAny),
    .strobes (strobes)
  );

  tap_outputs i_outputs (
    .tck          (tck),
    .rstAny       (rstAny),
    .strobes      (strobes),
    .testLogicRst (testLogicRst),
    .irSelect     (irSelect),
    .tdoEnable    (tdoEnable),
    .captureDr    (captureDr),
    .shiftDr      (shiftDr),
    .updateDr     (updateDr),
    .captureIr    (captureIr),
    .shiftIr      (shiftIr),
    .updateIr     (updateIr)
  );

endmodule

// File: rtl/tap_controller_chk.sv
module tap_controller_chk (
  input logic tck,
  input logic tms,
  input logic pwrRstN,
  input logic scanRstN,
  input logic testLogicRst,
  input logic irSelect,
  input logic tdoEnable,
  input logic captureDr,
  input logic shiftDr,
  input logic updateDr,
  input logic captureIr,
  input logic shiftIr,
  input logic updateIr
);

  logic rstIn;
  assign rstIn = ~pwrRstN | ~scanRstN;

  always @(posedge tck) begin
    if (rstIn) begin
      AST_RESET_FORCES: assert (testLogicRst && !tdoEnable && !shiftDr && !shiftIr
                                && !captureDr && !captureIr && !updateDr && !updateIr); // R1
    end
  end

  AST_RESET_HOLD: assert property (@(posedge tck) disable iff (rstIn)
    testLogicRst && tms |=> testLogicRst); // R2

  AST_RESET_EXIT: assert property (@(posedge tck) disable iff (rstIn)
    testLogicRst && !tms |=> !testLogicRst && !irSelect); // R4

  AST_DECODE_EXCL: assert property (@(posedge tck) disable iff (rstIn)
    $onehot0({testLogicRst, captureDr, updateDr, captureIr, updateIr})); // R6

  AST_CAPTURE_ONE: assert property (@(posedge tck) disable iff (rstIn)
    captureDr |=> !captureDr); // R6

  AST_CAPIR_PATH: assert property (@(posedge tck) disable iff (rstIn)
    captureIr |-> irSelect); // R5

  AST_UPIR_LEAVE: assert property (@(posedge tck) disable iff (rstIn)
    updateIr |=> !irSelect && !updateIr); // R8

  AST_OE_SHIFT: assert property (@(posedge tck) disable iff (rstIn)
    tdoEnable == (shiftDr || shiftIr)); // R9

  AST_SHIFT_EXCL: assert property (@(posedge tck) disable iff (rstIn)
    !(shiftDr && shiftIr)); // R7

endmodule

bind tap_controller tap_controller_chk i_chk (.*);

// File: tb/test_tap_controller.sv
`timescale 1ns/100ps
module test_tap_controller;

  logic tck = 1'b0;
  logic tms = 1'b1;
  logic pwrRstN = 1'b0;
  logic scanRstN = 1'b0;
  logic testLogicRst, irSelect, tdoEnable, captureDr, shiftDr, updateDr;
  logic captureIr, shiftIr, updateIr;

  int checks = 0;
  int errors = 0;
  int model = 0;
  bit done = 0;

  always #4 tck = ~tck;

  tap_controller i_tap_controller (
    .tck(tck), .tms(tms), .pwrRstN(pwrRstN), .scanRstN(scanRstN),
    .testLogicRst(testLogicRst), .irSelect(irSelect), .tdoEnable(tdoEnable),
    .captureDr(captureDr), .shiftDr(shiftDr), .updateDr(updateDr),
    .captureIr(captureIr), .shiftIr(shiftIr), .updateIr(updateIr)
  );

  // bench numbering: 0 reset,1 idle,2..8 DR column (sel,cap,sh,x1,pa,x2,up),9..15 IR column
  function automatic int nextSt(input int s, input bit t);
    case (s)
      0:  return t ? 0 : 1;
      1:  return t ? 2 : 1;
      2:  return t ? 9 : 3;
      9:  return t ? 0 : 10;
      8, 15: return t ? 2 : 1;
      default: begin
        int base = (s >= 9) ? 7 : 0;
        int loc = s - base;
        int nl;
        case (loc)
          3: nl = t ? 5 : 4;
          4: nl = t ? 5 : 4;
          5: nl = t ? 8 : 6;
          6: nl = t ? 7 : 6;
          7: nl = t ? 8 : 4;
          default: nl = 0;
        endcase
        return nl + base;
      end
    endcase
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b (model state %0d)", req, act, exp, model);
    end
  endtask

  task automatic checkComb();
    chk("R4 testLogicRst", testLogicRst, model == 0);
    chk("R5 irSelect", irSelect, model >= 9);
    chk("R6 captureDr", captureDr, model == 3);
    chk("R6 captureIr", captureIr, model == 10);
    chk("R8 updateDr", updateDr, model == 8);
    chk("R8 updateIr", updateIr, model == 15);
  endtask

  task automatic checkReg();
    chk("R7 shiftDr", shiftDr, model == 4);
    chk("R7 shiftIr", shiftIr, model == 11);
    chk("R9 tdoEnable", tdoEnable, model == 4 || model == 11);
  endtask

  // entered just after a falling edge; rk: 0 none, 1 power-up pulse, 2 scan pulse
  task automatic step(input bit t, input int rk);
    tms = t;
    @(posedge tck);
    model = nextSt(model, t);
    #2;
    checkComb();
    if (rk != 0) begin
      if (rk == 1) pwrRstN = 1'b0; else scanRstN = 1'b0;
      model = 0;
      #0.5;
      chk("R1 reset testLogicRst", testLogicRst, 1'b1);
      chk("R1 reset captureDr", captureDr, 1'b0);
      chk("R1 reset updateIr", updateIr, 1'b0);
      #0.5;
      pwrRstN = 1'b1;
      scanRstN = 1'b1;
    end
    @(negedge tck);
    #2;
    checkReg();
    #1;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit walk [] = '{0,1,0,0,1,0,1,0,1,1,1,1,0,0,1,0,1,0,1,1,0,0};
    void'($urandom(32'd20240611));
    // reset held across a rising edge, both inputs low
    @(posedge tck); #2;
    chk("R1 testLogicRst in reset", testLogicRst, 1'b1);
    @(negedge tck); #2;
    chk("R1 tdoEnable in reset", tdoEnable, 1'b0);
    chk("R1 shiftDr in reset", shiftDr, 1'b0);
    pwrRstN = 1'b1;
    @(posedge tck); #2;
    chk("R1 scan reset alone holds", testLogicRst, 1'b1);
    @(negedge tck); #1;
    scanRstN = 1'b1;
    #2;
    model = 0;

    // R2: directed walk over every state
    foreach (walk[i]) step(walk[i], 0);

    // R7 R9 with reset: enter Shift-DR, then reset in the same period
    step(1, 0); step(0, 0); step(0, 0); step(0, 0);
    chk("R7 shiftDr before reset", shiftDr, 1'b1);
    step(0, 2);
    chk("R1 shift cleared by scan reset", shiftDr, 1'b0);
    // Shift-IR, then power-up reset
    step(0, 0); step(1, 0); step(1, 0); step(0, 0); step(0, 0); step(0, 0);
    chk("R9 tdoEnable in Shift-IR", tdoEnable, 1'b1);
    step(0, 1);
    chk("R1 tdoEnable cleared by power reset", tdoEnable, 1'b0);

    // random walk with occasional resets and five-ones sequences
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom % 100;
      if (r < 3) begin
        for (int k = 0; k < 5; k++) step(1, 0);
        chk("R3 five ones reach reset", testLogicRst, 1'b1);
      end else if (r < 4) begin
        step($urandom % 2, 1 + ($urandom % 2));
      end else begin
        step(($urandom % 3) == 0, 0);
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule